// File: doc/BRIEF.md
# Binary-Coded Modulation Row Scan Sequencer

This block drives the refresh timing of a row-scanned RGB LED matrix. It walks through every bitplane of every row pair, and gives each bitplane a display time that doubles with its index, so that the eye integrates the planes into gray levels. Loading of column data into the panel shift registers is handled by a separate shifter. This block requests each load and waits for the shifter to report completion. Plane N is on display while plane N+1 is being shifted in.

Each interval boundary runs in this order. The output is blanked, the latch is pulsed and the row address lines are moved if needed. The plane and row counters then advance and the display timer starts for the plane just latched. Finally the output is enabled and the next load is requested. The base display period adapts. After each plane-0 interval it is filtered toward the measured interval length, so slow shifting lengthens all planes in proportion. A one-cycle swap request selects the other frame buffer at the next frame boundary. A frame counter can be read and cleared in the same cycle.

Top module: `bcm_scan_ctrl`

## Requirements
- R1: During and after reset, `oe_n` is 1, `lat` is 0, `frame_count` is 0, `active_buf` is 0 and `row_addr` holds ROWS-2 (ROWS = 2^ADDR_LINES). The plane counter starts at PLANES-1 and the row counter at ROWS-1, so the first boundary rolls both to 0 and issues a load of plane 0, row 0.
- R2: `lat` is 1 for exactly one cycle per boundary and only while `oe_n` is 1. `load_req` is 1 only in the first cycle of each `oe_n`=0 window. At a boundary without an address update, `oe_n` falls 2 cycles after the `lat` cycle.
- R3: Each `oe_n`=0 window lasts exactly base << p cycles, where p is the plane latched at that boundary.
- R4: When the window that just ended showed plane 0 (or PLANES is 1), the base becomes (7*base + m)/8, truncated, and is then raised to the minimum if it is below it. Here m is the number of cycles from the first `oe_n`=0 cycle to the `lat` cycle.
- R5: The base starts at 5*CHAIN_W. The minimum is the larger of MIN_FLOOR and TIMER_HZ/REFRESH_HZ/ROWS/(2^PLANES-1).
- R6: The address lines move only at boundaries that latch plane 0, and after the move they equal the row being shown. The lines are examined one at a time, from LSB to MSB. Only lines that differ are changed, at most one per cycle, and each change is followed by SETTLE_US*CLK_PER_US wait cycles. Such a boundary lasts ADDR_LINES+3+k*SETTLE cycles from `lat` to `oe_n` falling, where k is the number of changed lines.
- R7: `load_plane` steps 0..PLANES-1. When it wraps, `load_row` advances, and when the row wraps the sequence restarts at row 0.
- R8: `frame_count` increments once per row wrap. A cycle with `fc_read`=1 clears it, and the next value is 0, or 1 if a wrap happens in that same cycle.
- R9: A `swap_req` pulse sets `swap_pending`. At the next row wrap `active_buf` toggles once and `swap_pending` clears. Further requests while pending are absorbed.
- R10: If `load_done` has not arrived when the display time ends, the output stays blanked and the latch waits until the load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset (also restarts the scan) |
| oe_n | output | 1 | Panel output enable, active low |
| lat | output | 1 | Panel latch strobe |
| row_addr | output | ADDR_LINES | Row address lines |
| load_req | output | 1 | One-cycle request to shift the next plane |
| load_plane | output | PW | Plane index to shift |
| load_row | output | ADDR_LINES | Row pair to shift |
| load_buf | output | 1 | Frame buffer to read for the shift |
| load_done | input | 1 | Shifter has finished the requested load |
| swap_req | input | 1 | Request a buffer swap at the next frame boundary |
| swap_pending | output | 1 | A swap is waiting for the frame boundary |
| active_buf | output | 1 | Currently displayed frame buffer |
| fc_read | input | 1 | Read-and-clear strobe for the frame counter |
| frame_count | output | FC_W | Frames completed since the last clear |

## Verification
The scan runs in two regimes. In the first the shifter answers within three cycles, and the base period should stay fixed. In the second the shifter takes 150 cycles, so the plane-0 windows are stretched by the wait and the filtered base must grow step by step. The bench follows the requested plane and row to predict each window length, each blanking gap (plain, or with 0 to 3 address lines settled) and the address shown. Swap pulses given once and then twice while pending tell a single toggle apart from a repeated one, and a frame-counter read is checked against frames counted from the load requests.

// File: rtl/bcm_scan_ctrl.sv
module bcm_scan_ctrl #(
  parameter int PLANES     = 4,
  parameter int ADDR_LINES = 3,
  parameter int CHAIN_W    = 16,
  parameter int TIMER_HZ   = 120000,
  parameter int REFRESH_HZ = 250,
  parameter int MIN_FLOOR  = 6,
  parameter int BASE_W     = 20,
  parameter int SETTLE_US  = 8,
  parameter int CLK_PER_US = 1,
  parameter int FC_W       = 16,
  localparam int PW        = (PLANES > 1) ? $clog2(PLANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  oe_n,
  output logic                  lat,
  output logic [ADDR_LINES-1:0] row_addr,
  output logic                  load_req,
  output logic [PW-1:0]         load_plane,
  output logic [ADDR_LINES-1:0] load_row,
  output logic                  load_buf,
  input  logic                  load_done,
  input  logic                  swap_req,
  output logic                  swap_pending,
  output logic                  active_buf,
  input  logic                  fc_read,
  output logic [FC_W-1:0]       frame_count
);
  localparam int AW        = ADDR_LINES;
  localparam int ROWS      = 1 << AW;
  localparam int TW        = BASE_W + PLANES;
  localparam int MIN_RAW   = TIMER_HZ / REFRESH_HZ / ROWS / ((1 << PLANES) - 1);
  localparam int MIN_PER   = (MIN_RAW < MIN_FLOOR) ? MIN_FLOOR : MIN_RAW;
  localparam int INIT_BASE = 5 * CHAIN_W;
  localparam int SETTLE    = SETTLE_US * CLK_PER_US;
  localparam int SCW       = $clog2(SETTLE + 1);
  localparam int LIW       = $clog2(AW + 1);
  localparam logic [AW-1:0]     ADDR_RST = AW'(ROWS - 2);
  localparam logic [BASE_W-1:0] MIN_B    = BASE_W'(MIN_PER);

  typedef enum logic [2:0] {S_IDLE, S_LATCH, S_ADDR, S_ADV, S_DISP, S_WAIT} st_t;

  st_t               st;
  logic [PW-1:0]     plane_q;
  logic [AW-1:0]     row_q, addr_q;
  logic [BASE_W-1:0] base_q, meas_q;
  logic [TW-1:0]     tmr_q;
  logic [LIW-1:0]    li_q;
  logic [SCW-1:0]    sc_q;
  logic              req_q, loaded_q, pend_q, buf_q;
  logic [FC_W-1:0]   fc_q;

  wire last_plane = (plane_q == PW'(PLANES - 1));
  wire last_row   = (row_q == AW'(ROWS - 1));
  wire frame_inc  = (st == S_ADV) && last_plane && last_row;
  wire upd        = (PLANES == 1) || (plane_q == PW'(1));

  logic [BASE_W+3:0] acc;
  logic [BASE_W-1:0] filt, base_f, base_sel;
  always_comb begin
    acc      = ({4'd0, base_q} << 3) - {4'd0, base_q} + {4'd0, meas_q};
    filt     = acc[BASE_W+2:3];
    base_f   = (filt < MIN_B) ? MIN_B : filt;
    base_sel = upd ? base_f : base_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      plane_q  <= PW'(PLANES - 1);
      row_q    <= AW'(ROWS - 1);
      addr_q   <= ADDR_RST;
      base_q   <= BASE_W'(INIT_BASE);
      meas_q   <= '0;
      tmr_q    <= '0;
      li_q     <= '0;
      sc_q     <= '0;
      req_q    <= 1'b0;
      loaded_q <= 1'b1;
      pend_q   <= 1'b0;
      buf_q    <= 1'b0;
      fc_q     <= '0;
    end else begin
      req_q  <= (st == S_ADV);
      if (req_q) loaded_q <= 1'b0;
      else if (load_done) loaded_q <= 1'b1;
      pend_q <= (pend_q && !frame_inc) || swap_req;
      if (frame_inc && pend_q) buf_q <= ~buf_q;
      fc_q   <= fc_read ? FC_W'(frame_inc) : fc_q + FC_W'(frame_inc);
      case (st)
        S_IDLE:  st <= S_LATCH;
        S_LATCH: begin
          li_q <= '0;
          sc_q <= '0;
          st   <= (plane_q == '0) ? S_ADDR : S_ADV;
        end
        S_ADDR: begin
          if (sc_q != '0) sc_q <= sc_q - 1'b1;
          else if (li_q == LIW'(AW)) st <= S_ADV;
          else begin
            if (addr_q[li_q] != row_q[li_q]) begin
              addr_q[li_q] <= row_q[li_q];
              sc_q         <= SCW'(SETTLE);
            end
            li_q <= li_q + 1'b1;
          end
        end
        S_ADV: begin
          base_q  <= base_sel;
          tmr_q   <= TW'(base_sel) << plane_q;
          meas_q  <= '0;
          plane_q <= last_plane ? '0 : plane_q + 1'b1;
          if (last_plane) row_q <= last_row ? '0 : row_q + 1'b1;
          st      <= S_DISP;
        end
        S_DISP: begin
          if (meas_q != '1) meas_q <= meas_q + 1'b1;
          if (tmr_q <= TW'(1)) st <= S_WAIT;
          else tmr_q <= tmr_q - 1'b1;
        end
        S_WAIT: begin
          if (meas_q != '1) meas_q <= meas_q + 1'b1;
          if (loaded_q) st <= S_LATCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign oe_n         = (st != S_DISP);
  assign lat          = (st == S_LATCH);
  assign row_addr     = addr_q;
  assign load_req     = req_q;
  assign load_plane   = plane_q;
  assign load_row     = row_q;
  assign load_buf     = buf_q;
  assign swap_pending = pend_q;
  assign active_buf   = buf_q;
  assign frame_count  = fc_q;

  assert_lat_blanked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lat |-> oe_n);
  assert_load_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> !oe_n);
  assert_addr_blanked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> oe_n);
  assert_addr_one_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_addr ^ $past(row_addr)) <= 1);
  assert_addr_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |=> $stable(row_addr));
  assert_base_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    base_q >= MIN_B);
  assert_fc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fc_read |=> frame_count <= FC_W'(1));
  assert_swap_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_buf) |-> $past(swap_pending));
endmodule

// File: tb/bcm_scan_ctrl_tb.sv
module bcm_scan_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4, AW = 3, ROWS = 8, CW = 16, SETTLE = 8, MINP = 6;
  localparam int PW = 2;

  logic clk = 0, rst_n = 0;
  logic oe_n, lat, load_req, load_buf, swap_pending, active_buf;
  logic [AW-1:0] row_addr, load_row;
  logic [PW-1:0] load_plane;
  logic load_done = 0, swap_req = 0, fc_read = 0;
  logic [15:0] frame_count;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, t_low = 0, t_lat = 0, exp_gap = 2, exp_len = 0;
  int base_m = 5 * CW, next_plane = P - 1, next_row = ROWS - 2;
  int disp_plane = P - 1, disp_row = ROWS - 2;
  int frames_m = 0, ld_lat = 3, ld_cnt = 0, plane0_updates = 0;
  bit prev_oe = 1, loaded_m = 1, mon_on = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcm_scan_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .lat(lat), .row_addr(row_addr),
    .load_req(load_req), .load_plane(load_plane), .load_row(load_row),
    .load_buf(load_buf), .load_done(load_done), .swap_req(swap_req),
    .swap_pending(swap_pending), .active_buf(active_buf), .fc_read(fc_read),
    .frame_count(frame_count));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (prev_oe && !oe_n) begin
        t_low = cyc;
        disp_plane = next_plane;
        disp_row = next_row;
        check(cyc - t_lat == exp_gap, "R2/R6 lat-to-enable gap", cyc - t_lat, exp_gap);
        check(int'(row_addr) == disp_row, "R6 address equals shown row", row_addr, disp_row);
        exp_len = base_m << disp_plane;
      end
      if (!prev_oe && oe_n)
        check(cyc - t_low == exp_len, "R3 weighted window", cyc - t_low, exp_len);
      if (lat) begin
        check(oe_n == 1'b1, "R2 latch while blanked", oe_n, 1);
        check(loaded_m, "R10 latch after load done", loaded_m, 1);
        if (disp_plane == 0) begin
          base_m = (7 * base_m + (cyc - t_low)) / 8;
          if (base_m < MINP) base_m = MINP;
          plane0_updates++;
        end
        t_lat = cyc;
        exp_gap = (next_plane == 0)
                ? AW + 3 + $countones(row_addr ^ AW'(next_row)) * SETTLE : 2;
      end
      load_done = 0;
      if (load_req) begin
        check(oe_n == 1'b0, "R2 request in display window", oe_n, 0);
        check(int'(load_plane) == (next_plane + 1) % P, "R7 plane order",
              load_plane, (next_plane + 1) % P);
        if (load_plane == 0)
          check(int'(load_row) == (next_row + 1) % ROWS || next_plane == P - 1 && cyc < 700,
                "R7 row order", load_row, (next_row + 1) % ROWS);
        next_plane = load_plane;
        next_row = load_row;
        if (load_plane == 0 && load_row == 0) frames_m++;
        loaded_m = 0;
        ld_cnt = ld_lat;
      end else if (ld_cnt > 0) begin
        ld_cnt--;
        if (ld_cnt == 0) begin
          load_done = 1;
          loaded_m = 1;
        end
      end
      prev_oe = oe_n;
    end
  end

  task automatic wait_frames(input int n);
    int target = frames_m + n;
    while (frames_m < target) @(negedge clk);
  endtask

  task automatic wait_frame_start(output bit b);
    do @(negedge clk); while (!(load_req && load_plane == 0 && load_row == 0));
    b = load_buf;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(oe_n == 1, "R1 reset oe_n", oe_n, 1);
    check(lat == 0, "R1 reset lat", lat, 0);
    check(frame_count == 0, "R1 reset frame_count", frame_count, 0);
    check(active_buf == 0, "R1 reset active_buf", active_buf, 0);
    check(int'(row_addr) == ROWS - 2, "R1 reset row_addr", row_addr, ROWS - 2);
    rst_n = 1;
    mon_on = 1;
    do @(negedge clk); while (!load_req);
    check(load_plane == 0 && load_row == 0, "R1 first load is plane 0 row 0",
          {load_row, load_plane}, 0);
    check(frame_count == 1, "R1 first boundary counts a frame", frame_count, 1);
  endtask

  task automatic test_fast_scan();
    int b0 = base_m;
    wait_frames(2);
    check(base_m == b0, "R5 base holds at 5*CHAIN_W with fast loads", base_m, b0);
    check(int'(frame_count) == frames_m, "R8 frame count", frame_count, frames_m);
  endtask

  task automatic test_slow_load();
    int b0 = base_m, u0 = plane0_updates;
    ld_lat = 150;
    wait_frames(1);
    ld_lat = 3;
    check(plane0_updates > u0, "R4 filter updated after plane 0", plane0_updates, u0 + 1);
    check(base_m > b0, "R4 base grows with slow loads", base_m, b0 + 1);
    wait_frames(1);
  endtask

  task automatic test_swap();
    bit b_old, b_new;
    @(negedge clk);
    b_old = active_buf;
    swap_req = 1;
    @(negedge clk);
    swap_req = 0;
    check(swap_pending == 1, "R9 swap pending set", swap_pending, 1);
    repeat (5) @(negedge clk);
    swap_req = 1;
    @(negedge clk);
    swap_req = 0;
    check(active_buf == b_old, "R9 no toggle before frame end", active_buf, b_old);
    wait_frame_start(b_new);
    check(b_new == !b_old, "R9 buffer toggled at frame end", b_new, !b_old);
    check(swap_pending == 0, "R9 pending cleared", swap_pending, 0);
    wait_frame_start(b_new);
    check(b_new == !b_old, "R9 repeated request absorbed", b_new, !b_old);
  endtask

  task automatic test_fc_read();
    do @(negedge clk); while (!(load_req && load_plane == 1));
    check(int'(frame_count) == frames_m, "R8 count before read", frame_count, frames_m);
    fc_read = 1;
    @(negedge clk);
    fc_read = 0;
    check(frame_count == 0, "R8 read clears count", frame_count, 0);
    frames_m = 0;
    wait_frames(1);
    check(int'(frame_count) == 1, "R8 count resumes after clear", frame_count, 1);
  endtask

  initial begin
    test_reset();
    test_fast_scan();
    test_slow_load();
    test_swap();
    test_fc_read();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule